// File: doc/BRIEF.md
# Banked Multi-Port Tile Buffer

This block is an on-chip store for one tile of target samples. Several processing elements share it, and each element has a private read port and a private write port, so that all of them can run a read-modify-write on their own target sample in the same clock cycle. The storage is split into interleaved banks. Each bank has one read port and one write port. A sample's address picks its bank and its word inside that bank, so with B banks the buffer can serve up to 2B ports per cycle, B reads and B writes.

Samples are placed in row-major order, so neighbouring samples of a row fall into neighbouring banks. The address generator upstream is expected to issue accesses that do not collide. If two reads, or two writes, do target the same bank in one cycle, the lower-numbered port is served. The other access is dropped and a conflict flag for that direction is raised in the same cycle.

Top module: `banked_tile_buffer`

## Requirements
- R1: The bank of an access is the low log2(NUM_BANKS) bits of its address and the word inside the bank is the remaining upper bits, so addresses 0 and 4 share bank 0 while addresses 0 and 1 do not (NUM_BANKS = 4).
- R2: A granted read returns its sample one clock cycle later. `rd_valid[p]` is high in exactly that cycle.
- R3: Reads from all ports to pairwise distinct banks in one cycle are all served, and `rd_conflict` stays low.
- R4: Writes from all ports to pairwise distinct banks in one cycle are all stored, and `wr_conflict` stays low.
- R5: When two or more reads target one bank in a cycle, `rd_conflict` is high in that same cycle. The lowest-numbered of those ports gets its data and the others get no `rd_valid`.
- R6: When two or more writes target one bank in a cycle, `wr_conflict` is high in that same cycle. Only the lowest-numbered of those ports updates storage, and the locations the other ports addressed keep their previous contents.
- R7: A read and a write to the same address in one cycle are legal. The read returns the value held before the write, and a later read returns the written value.
- R8: After synchronous reset, `rd_valid`, `rd_conflict` and `wr_conflict` are all low while no port requests.
- R9: A read port whose `rd_valid` is low drives all-zero `rd_data`. A sample is 64 bits: real part in bits 63:32, imaginary part in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | NUM_PE | Read request, one bit per element |
| rd_addr | input | NUM_PE x AW | Read address per element |
| rd_data | output | NUM_PE x 64 | Read sample per element, one cycle after the request |
| rd_valid | output | NUM_PE | Read data valid per element |
| wr_en | input | NUM_PE | Write request, one bit per element |
| wr_addr | input | NUM_PE x AW | Write address per element |
| wr_data | input | NUM_PE x 64 | Write sample per element |
| rd_conflict | output | 1 | Some read was dropped this cycle by a bank collision |
| wr_conflict | output | 1 | Some write was dropped this cycle by a bank collision |

## Verification
The conflict flags are combinational and are due in the request cycle itself, so the bench samples them 1 ns after driving the inputs on the falling edge, before the next rising edge. Read data and `rd_valid` pass through one register and are due right after the next rising edge, so the bench samples them 1 ns after that edge. Writes take effect at that same edge, and the bench checks them through later reads. Expected values come from a reference array in the bench that applies the lowest-port-wins rule per bank and hands out pre-write contents for reads issued in the write cycle.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

    localparam int SAMPLE_W = 64;

    // One complex target sample: real part high, imaginary part low
    typedef struct packed {
        logic [31:0] re;
        logic [31:0] im;
    } sample_t;

    // Width of an index that selects one of n items (at least one bit)
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tbuf_bank.sv
module tbuf_bank
    import tbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int WW   = idx_w(DEPTH)
) (
    input  logic          clk,
    input  logic          re,
    input  logic [WW-1:0] raddr,
    output sample_t       rdata,
    input  logic          we,
    input  logic [WW-1:0] waddr,
    input  sample_t       wdata
);

    sample_t mem [DEPTH];

    // Nonblocking update: a same-address read sees the old word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/tbuf_port_arb.sv
module tbuf_port_arb
    import tbuf_pkg::*;
#(
    parameter int NP   = 4,
    parameter int NB   = 4,
    localparam int BW  = idx_w(NB),
    localparam int PW  = idx_w(NP)
) (
    input  logic [NP-1:0]         req,
    input  logic [NP-1:0][BW-1:0] bank_id,
    output logic [NB-1:0]         bank_act,
    output logic [NB-1:0][PW-1:0] bank_src,
    output logic [NP-1:0]         won
);

    // Per bank: lowest-numbered requesting port wins
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_comb begin
            bank_act[b] = 1'b0;
            bank_src[b] = '0;
            for (int p = NP - 1; p >= 0; p--) begin
                if (req[p] && (bank_id[p] == BW'(b))) begin
                    bank_act[b] = 1'b1;
                    bank_src[b] = PW'(p);
                end
            end
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign won[p] = req[p] && (bank_src[bank_id[p]] == PW'(p));
    end

endmodule

// File: rtl/banked_tile_buffer.sv
module banked_tile_buffer
    import tbuf_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_DEPTH = 16,
    parameter int NUM_PE     = 4,
    localparam int BW        = idx_w(NUM_BANKS),
    localparam int WW        = idx_w(BANK_DEPTH),
    localparam int AW        = BW + WW,
    localparam int PW        = idx_w(NUM_PE)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PE-1:0]                rd_en,
    input  logic [NUM_PE-1:0][AW-1:0]        rd_addr,
    output logic [NUM_PE-1:0][SAMPLE_W-1:0]  rd_data,
    output logic [NUM_PE-1:0]                rd_valid,
    input  logic [NUM_PE-1:0]                wr_en,
    input  logic [NUM_PE-1:0][AW-1:0]        wr_addr,
    input  logic [NUM_PE-1:0][SAMPLE_W-1:0]  wr_data,
    output logic                             rd_conflict,
    output logic                             wr_conflict
);

    // Address split: bank in low bits, word in high bits
    logic [NUM_PE-1:0][BW-1:0] rd_bank, wr_bank;
    logic [NUM_PE-1:0][WW-1:0] rd_word, wr_word;

    for (genvar p = 0; p < NUM_PE; p++) begin : g_split
        assign rd_bank[p] = rd_addr[p][BW-1:0];
        assign rd_word[p] = rd_addr[p][AW-1:BW];
        assign wr_bank[p] = wr_addr[p][BW-1:0];
        assign wr_word[p] = wr_addr[p][AW-1:BW];
    end

    logic [NUM_BANKS-1:0]         rd_act, wr_act;
    logic [NUM_BANKS-1:0][PW-1:0] rd_src, wr_src;
    logic [NUM_PE-1:0]            rd_won, wr_won;

    tbuf_port_arb #(.NP(NUM_PE), .NB(NUM_BANKS)) u_rd_arb (
        .req      (rd_en),
        .bank_id  (rd_bank),
        .bank_act (rd_act),
        .bank_src (rd_src),
        .won      (rd_won)
    );

    tbuf_port_arb #(.NP(NUM_PE), .NB(NUM_BANKS)) u_wr_arb (
        .req      (wr_en),
        .bank_id  (wr_bank),
        .bank_act (wr_act),
        .bank_src (wr_src),
        .won      (wr_won)
    );

    assign rd_conflict = |(rd_en & ~rd_won);
    assign wr_conflict = |(wr_en & ~wr_won);

    sample_t bank_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mem
        tbuf_bank #(.DEPTH(BANK_DEPTH)) u_bank (
            .clk   (clk),
            .re    (rd_act[b]),
            .raddr (rd_word[rd_src[b]]),
            .rdata (bank_q[b]),
            .we    (wr_act[b]),
            .waddr (wr_word[wr_src[b]]),
            .wdata (sample_t'(wr_data[wr_src[b]]))
        );
    end

    // Return path: remember which bank each granted read went to
    logic [NUM_PE-1:0]         valid_q;
    logic [NUM_PE-1:0][BW-1:0] bank_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= '0;
            bank_sel_q <= '0;
        end else begin
            valid_q    <= rd_won;
            bank_sel_q <= rd_bank;
        end
    end

    assign rd_valid = valid_q;

    for (genvar p = 0; p < NUM_PE; p++) begin : g_ret
        assign rd_data[p] = valid_q[p] ? SAMPLE_W'(bank_q[bank_sel_q[p]]) : '0;
    end

endmodule

// File: rtl/banked_tile_buffer_chk.sv
module banked_tile_buffer_chk
    import tbuf_pkg::*;
#(
    parameter int NUM_PE = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_PE-1:0]               rd_en,
    input logic [NUM_PE-1:0]               wr_en,
    input logic [NUM_PE-1:0]               rd_valid,
    input logic [NUM_PE-1:0][SAMPLE_W-1:0] rd_data,
    input logic                            rd_conflict,
    input logic                            wr_conflict
);

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_conflict |=> (rd_valid == $past(rd_en)));

    // R2
    rd_valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid != '0) |-> (($past(rd_en) & rd_valid) == rd_valid));

    // R5
    rd_conflict_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
        rd_conflict |-> ($countones(rd_en) >= 2));

    // R5
    rd_conflict_drops_chk: assert property (@(posedge clk) disable iff (rst)
        rd_conflict |=> ($countones(rd_valid) < $countones($past(rd_en))));

    // R6
    wr_conflict_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wr_conflict |-> ($countones(wr_en) >= 2));

    // R8
    idle_no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_en == '0) && (wr_en == '0)) |-> (!rd_conflict && !wr_conflict));

    for (genvar p = 0; p < NUM_PE; p++) begin : g_port
        // R9
        idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !rd_valid[p] |-> (rd_data[p] == '0));
    end

endmodule

bind banked_tile_buffer banked_tile_buffer_chk #(.NUM_PE(NUM_PE)) u_chk (.*);

// File: tb/banked_tile_buffer_tb.sv
module banked_tile_buffer_tb;

    localparam int NB   = 4;
    localparam int DEP  = 16;
    localparam int NP   = 4;
    localparam int BW   = 2;
    localparam int AW   = 6;
    localparam int NW   = NB * DEP;

    localparam logic [63:0] VEC [8] = '{
        64'h3F80_0000_0000_0000, 64'hBF80_0000_4000_0000,
        64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0001,
        64'h0000_0000_FFFF_FFFF, 64'hA5A5_5A5A_C3C3_3C3C,
        64'h4049_0FDB_C049_0FDB, 64'h0F0F_F0F0_7777_8888
    };

    logic clk = 1'b0;
    logic rst;
    logic [NP-1:0]         rd_en, wr_en;
    logic [NP-1:0][AW-1:0] rd_addr, wr_addr;
    logic [NP-1:0][63:0]   rd_data, wr_data;
    logic [NP-1:0]         rd_valid;
    logic                  rd_conflict, wr_conflict;

    int errors = 0;
    int checks = 0;
    logic [63:0] model [NW];

    always #2 clk = ~clk;

    banked_tile_buffer #(.NUM_BANKS(NB), .BANK_DEPTH(DEP), .NUM_PE(NP)) u_dut (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_conflict(rd_conflict), .wr_conflict(wr_conflict)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access cycle with full checking against the bench's own model
    task automatic run_cycle(input string tag,
                             input logic [NP-1:0] re, input logic [NP-1:0][AW-1:0] ra,
                             input logic [NP-1:0] we, input logic [NP-1:0][AW-1:0] wa,
                             input logic [NP-1:0][63:0] wd);
        logic [NP-1:0]       ev;
        logic [NP-1:0][63:0] ed;
        logic                erc, ewc;
        logic                rwin, wwin;
        erc = 1'b0; ewc = 1'b0;
        @(negedge clk);
        rd_en = re; rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd;
        for (int p = 0; p < NP; p++) begin
            rwin = re[p];
            for (int q = 0; q < p; q++)
                if (re[q] && ra[q][BW-1:0] == ra[p][BW-1:0]) rwin = 1'b0;
            if (re[p] && !rwin) erc = 1'b1;
            ev[p] = rwin;
            ed[p] = rwin ? model[ra[p]] : 64'h0;
            wwin = we[p];
            for (int q = 0; q < p; q++)
                if (we[q] && wa[q][BW-1:0] == wa[p][BW-1:0]) wwin = 1'b0;
            if (we[p] && !wwin) ewc = 1'b1;
        end
        #1;
        chk({tag, " rd_conflict"}, 64'(rd_conflict), 64'(erc));
        chk({tag, " wr_conflict"}, 64'(wr_conflict), 64'(ewc));
        @(posedge clk);
        for (int p = NP - 1; p >= 0; p--) begin
            wwin = we[p];
            for (int q = 0; q < p; q++)
                if (we[q] && wa[q][BW-1:0] == wa[p][BW-1:0]) wwin = 1'b0;
            if (wwin) model[wa[p]] = wd[p];
        end
        #1;
        rd_en = '0; wr_en = '0;
        for (int p = 0; p < NP; p++) begin
            chk($sformatf("%s rd_valid[%0d]", tag, p), 64'(rd_valid[p]), 64'(ev[p]));
            chk($sformatf("%s rd_data[%0d]", tag, p), rd_data[p], ed[p]);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NP-1:0][AW-1:0] ra, wa;
        logic [NP-1:0][63:0]   wd;
        rst = 1'b1;
        rd_en = '0; wr_en = '0; rd_addr = '0; wr_addr = '0; wr_data = '0;
        for (int i = 0; i < NW; i++) model[i] = 64'h0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R8 / R9: reset state
        chk("R8 rd_valid after reset", 64'(rd_valid), 64'h0);
        chk("R8 rd_conflict after reset", 64'(rd_conflict), 64'h0);
        chk("R8 wr_conflict after reset", 64'(wr_conflict), 64'h0);
        chk("R9 rd_data idle", rd_data[0], 64'h0);

        // R4 / R1: vector table, one row per cycle, all ports to distinct banks
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < NP; p++) begin
                wa[p] = AW'(i * NB + p);
                wd[p] = VEC[i] ^ {32'(p), 32'(i)};
                ra[p] = '0;
            end
            run_cycle("R4 table write", '0, ra, '1, wa, wd);
        end
        // R3 / R2: read the table back, all ports to distinct banks
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < NP; p++) begin
                ra[p] = AW'(i * NB + ((p + i) % NB));
                wd[p] = '0;
            end
            run_cycle("R3 table read", '1, ra, '0, ra, wd);
        end

        wd = '0;
        // R1 / R5: addresses 1 and 5 share bank 1; port 0 wins over port 2
        ra = '0; ra[0] = 6'd1; ra[2] = 6'd5;
        run_cycle("R5 R1 read collision", 4'b0101, ra, '0, ra, wd);
        // R1: addresses 0 and 1 sit in different banks
        ra = '0; ra[0] = 6'd0; ra[1] = 6'd1;
        run_cycle("R1 adjacent banks", 4'b0011, ra, '0, ra, wd);

        // R6: three writes to bank 1; only port 0 lands
        wa = '0; wa[0] = 6'd9; wa[1] = 6'd9; wa[3] = 6'd13;
        wd[0] = 64'hAAAA_0000_1111_0000; wd[1] = 64'hBBBB_0000_2222_0000;
        wd[3] = 64'hCCCC_0000_3333_0000;
        run_cycle("R6 write collision", '0, wa, 4'b1011, wa, wd);
        wd = '0;
        ra = '0; ra[0] = 6'd9; ra[1] = 6'd14; ra[2] = 6'd15; ra[3] = 6'd13;
        run_cycle("R6 readback", 4'b1001, ra, '0, ra, wd);

        // R7: read and write address 2 in the same cycle
        ra = '0; ra[1] = 6'd2;
        wa = '0; wa[2] = 6'd2;
        wd[2] = 64'h5555_6666_7777_8888;
        run_cycle("R7 same-cycle read", 4'b0010, ra, 4'b0100, wa, wd);
        wd = '0;
        run_cycle("R7 later read", 4'b0010, ra, '0, wa, wd);

        // R2 / R9: idle cycle after reads
        run_cycle("R9 idle", '0, ra, '0, wa, wd);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule